// File: doc/BRIEF.md
# Preemptive Interrupt Priority Arbiter

This block chooses which of a set of interrupt request lines a core should service next, and decides whether that request may interrupt the handler already running. Each configurable line has a 4-bit priority, where a lower number is more urgent. A binary-point setting splits every priority into an upper group field and a lower subpriority field. Only the group field decides preemption. Pending requests are ordered by group, then by subpriority, then by lowest line index. Three fixed system exception lines rank above every configurable level.

The core sees an entry offer (`entry_valid_o`, `entry_id_o`) and accepts it with `entry_ack_i`. When a handler finishes, the core pulses `ret_i`. Accepting an entry pushes the interrupted level onto a nesting stack. A return pops it and restores that level. The pending requests are then weighed again against the restored level.

Top module: `irq_prio_arbiter`

## Requirements
- R1: After reset nothing is pending, no handler is active, the nesting depth is 0 and no entry is offered. All enables reset to 1, all priorities reset to 0 and the binary point resets to 0.
- R2: Request inputs are level sensitive. A high `req_i[i]` or `sys_req_i[s]` sets its pending bit at the next clock edge. Pending bit layout: bits 0..2 are the system lines and bit 3+i is configurable line i. An accepted entry clears its pending bit at the accept edge, and the clear wins over a request still held high. A request still high re-sets the bit one edge later.
- R3: A configurable line whose enable bit is 0 is never offered for entry, but its pending bit is kept. When it is re-enabled it competes again.
- R4: With no handler active, any pending eligible request is offered in the same cycle its pending bit is visible.
- R5: Entry IDs are: system line s gives ID s, configurable line i gives ID 3+i. Among eligible pending requests the lowest group wins, then the lowest subpriority, then the lowest ID.
- R6: An offer is made only when the candidate's group rank is strictly lower than that of the active handler. A request of the same group stays pending and is not offered.
- R7: The number of subpriority bits is min(binary point, 4). The group is the priority shifted right by that count, and the subpriority is the bits below it. A binary point of 4 or more puts every configurable line in one group, so none preempts another.
- R8: System lines rank as levels 0, 1, 2, above every configurable group. Among system lines the lower index wins. A system line preempts any configurable handler.
- R9: An accepted entry (offer and acknowledge in the same cycle) raises the depth by 1. The entered ID becomes the active ID at the next edge.
- R10: A return with depth above 0 lowers the depth by 1 and restores the interrupted handler's ID and level. No entry is offered in a cycle where `ret_i` is high. Pending requests are weighed against the restored level in the following cycle.
- R11: When the depth equals the stack capacity (4), no entry is offered, whatever is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | N_REQ | Level-sensitive configurable request lines |
| sys_req_i | input | 3 | Level-sensitive system exception lines |
| prio_we_i | input | 1 | Priority write strobe |
| prio_idx_i | input | clog2(N_REQ) | Line whose priority is written |
| prio_wdata_i | input | 4 | Priority value to write |
| en_we_i | input | 1 | Enable vector write strobe |
| en_wdata_i | input | N_REQ | New enable vector |
| bp_we_i | input | 1 | Binary point write strobe |
| bp_wdata_i | input | 3 | New binary point |
| entry_ack_i | input | 1 | Core accepts the offered entry |
| ret_i | input | 1 | Core finished the active handler |
| entry_valid_o | output | 1 | An entry is offered |
| entry_id_o | output | clog2(N_REQ+3) | ID of the offered request |
| active_valid_o | output | 1 | A handler is active |
| active_id_o | output | clog2(N_REQ+3) | ID of the active handler |
| depth_o | output | clog2(DEPTH+1) | Current nesting depth |
| pending_o | output | N_REQ+3 | Pending bits, system lines in the low bits |

## Verification
A request reaches `pending_o` one edge after it is raised. The entry offer is combinational from the registered pending, priority and stack state, so it is due in that same following cycle. `active_id_o`, `depth_o` and the cleared pending bit are due one edge after an accept or a return. The bench changes inputs just after a rising edge and compares every output against its behavioural model just after the falling edge. Its model advances at each rising edge, so every check falls in the cycle where the result is due.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int PRIO_W = 4;
  localparam int BP_W   = 3;
  localparam int N_SYS  = 3;
  localparam int RANK_W = $clog2(N_SYS + (1 << PRIO_W) + 1);

  typedef logic [PRIO_W-1:0] prio_t;
  typedef logic [RANK_W-1:0] rank_t;

  localparam rank_t RANK_IDLE = '1;

  function automatic int sub_bits(logic [BP_W-1:0] bp);
    return (int'(bp) > PRIO_W) ? PRIO_W : int'(bp);
  endfunction

  function automatic prio_t grp_of(prio_t p, logic [BP_W-1:0] bp);
    return prio_t'(p >> sub_bits(bp));
  endfunction

  function automatic prio_t sub_of(prio_t p, logic [BP_W-1:0] bp);
    return prio_t'(int'(p) & ((1 << sub_bits(bp)) - 1));
  endfunction

  function automatic rank_t cfg_rank(prio_t p, logic [BP_W-1:0] bp);
    return rank_t'(N_SYS + int'(grp_of(p, bp)));
  endfunction
endpackage

// File: rtl/irq_pend_track.sv
module irq_pend_track #(
  parameter int N = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) pend_o <= '0;
    else        pend_o <= (pend_o | set_i) & ~clr_i;
  end
endmodule

// File: rtl/irq_select.sv
module irq_select
  import irq_arb_pkg::*;
#(
  parameter int N    = 11,
  parameter int ID_W = 4
) (
  input  logic [N-1:0]    elig_i,
  input  rank_t           rank_i [N],
  input  prio_t           sub_i  [N],
  output logic            found_o,
  output logic [ID_W-1:0] id_o,
  output rank_t           rank_o
);
  prio_t best_sub;

  always_comb begin
    found_o  = 1'b0;
    id_o     = '0;
    rank_o   = RANK_IDLE;
    best_sub = '0;
    for (int k = 0; k < N; k++) begin
      if (elig_i[k] && (!found_o || rank_i[k] < rank_o ||
                        (rank_i[k] == rank_o && sub_i[k] < best_sub))) begin
        found_o  = 1'b1;
        id_o     = ID_W'(k);
        rank_o   = rank_i[k];
        best_sub = sub_i[k];
      end
    end
  end
endmodule

// File: rtl/irq_nest_stack.sv
module irq_nest_stack
  import irq_arb_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int ID_W  = 4,
  localparam int DEPTH_W = $clog2(DEPTH + 1),
  localparam int IDX_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               push_i,
  input  rank_t              push_rank_i,
  input  logic [ID_W-1:0]    push_id_i,
  input  logic               pop_i,
  output rank_t              act_rank_o,
  output logic [ID_W-1:0]    act_id_o,
  output logic [DEPTH_W-1:0] depth_o
);
  rank_t           stk_rank [DEPTH];
  logic [ID_W-1:0] stk_id   [DEPTH];
  logic [IDX_W-1:0] wr_idx, rd_idx;

  assign wr_idx = IDX_W'(depth_o);
  assign rd_idx = IDX_W'(depth_o - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_rank_o <= RANK_IDLE;
      act_id_o   <= '0;
      depth_o    <= '0;
      for (int k = 0; k < DEPTH; k++) begin
        stk_rank[k] <= RANK_IDLE;
        stk_id[k]   <= '0;
      end
    end else if (pop_i && depth_o != '0) begin
      act_rank_o <= stk_rank[rd_idx];
      act_id_o   <= stk_id[rd_idx];
      depth_o    <= depth_o - 1'b1;
    end else if (push_i) begin
      stk_rank[wr_idx] <= act_rank_o;
      stk_id[wr_idx]   <= act_id_o;
      act_rank_o       <= push_rank_i;
      act_id_o         <= push_id_i;
      depth_o          <= depth_o + 1'b1;
    end
  end
endmodule

// File: rtl/irq_prio_arbiter.sv
module irq_prio_arbiter
  import irq_arb_pkg::*;
#(
  parameter int N_REQ = 8,
  parameter int DEPTH = 4,
  localparam int N_TOT   = N_SYS + N_REQ,
  localparam int ID_W    = $clog2(N_TOT),
  localparam int IDX_W   = (N_REQ > 1) ? $clog2(N_REQ) : 1,
  localparam int DEPTH_W = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_REQ-1:0]   req_i,
  input  logic [N_SYS-1:0]   sys_req_i,
  input  logic               prio_we_i,
  input  logic [IDX_W-1:0]   prio_idx_i,
  input  logic [PRIO_W-1:0]  prio_wdata_i,
  input  logic               en_we_i,
  input  logic [N_REQ-1:0]   en_wdata_i,
  input  logic               bp_we_i,
  input  logic [BP_W-1:0]    bp_wdata_i,
  input  logic               entry_ack_i,
  input  logic               ret_i,
  output logic               entry_valid_o,
  output logic [ID_W-1:0]    entry_id_o,
  output logic               active_valid_o,
  output logic [ID_W-1:0]    active_id_o,
  output logic [DEPTH_W-1:0] depth_o,
  output logic [N_TOT-1:0]   pending_o
);
  prio_t            prio_q [N_REQ];
  logic [N_REQ-1:0] en_q;
  logic [BP_W-1:0]  bp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= '1;
      bp_q <= '0;
      for (int k = 0; k < N_REQ; k++) prio_q[k] <= '0;
    end else begin
      if (en_we_i)   en_q <= en_wdata_i;
      if (bp_we_i)   bp_q <= bp_wdata_i;
      if (prio_we_i) prio_q[prio_idx_i] <= prio_wdata_i;
    end
  end

  // Per-source arbitration keys
  rank_t rank_arr [N_TOT];
  prio_t sub_arr  [N_TOT];

  for (genvar s = 0; s < N_SYS; s++) begin : g_sys
    assign rank_arr[s] = rank_t'(s);
    assign sub_arr[s]  = '0;
  end
  for (genvar i = 0; i < N_REQ; i++) begin : g_cfg
    assign rank_arr[N_SYS+i] = cfg_rank(prio_q[i], bp_q);
    assign sub_arr[N_SYS+i]  = sub_of(prio_q[i], bp_q);
  end

  // Named internal events
  logic             cand_found;
  logic [ID_W-1:0]  cand_id;
  rank_t            cand_rank;
  rank_t            act_rank;
  logic             preempt_ok;
  logic             accept;
  logic             pop;
  logic [N_TOT-1:0] elig;
  logic [N_TOT-1:0] clr_vec;

  assign elig = pending_o & {en_q, {N_SYS{1'b1}}};

  irq_select #(.N(N_TOT), .ID_W(ID_W)) u_sel (
    .elig_i (elig),
    .rank_i (rank_arr),
    .sub_i  (sub_arr),
    .found_o(cand_found),
    .id_o   (cand_id),
    .rank_o (cand_rank)
  );

  assign preempt_ok = cand_found && (cand_rank < act_rank) &&
                      (depth_o < DEPTH_W'(DEPTH)) && !ret_i;
  assign accept     = preempt_ok && entry_ack_i;
  assign pop        = ret_i && (depth_o != '0);
  assign clr_vec    = accept ? (N_TOT'(1) << cand_id) : '0;

  irq_pend_track #(.N(N_TOT)) u_pend (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i ({req_i, sys_req_i}),
    .clr_i (clr_vec),
    .pend_o(pending_o)
  );

  irq_nest_stack #(.DEPTH(DEPTH), .ID_W(ID_W)) u_stack (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_i     (accept),
    .push_rank_i(cand_rank),
    .push_id_i  (cand_id),
    .pop_i      (pop),
    .act_rank_o (act_rank),
    .act_id_o   (active_id_o),
    .depth_o    (depth_o)
  );

  assign entry_valid_o  = preempt_ok;
  assign entry_id_o     = cand_id;
  assign active_valid_o = (depth_o != '0);
endmodule

// File: rtl/irq_arb_checker.sv
module irq_arb_checker
  import irq_arb_pkg::*;
#(
  parameter int N_TOT   = 11,
  parameter int ID_W    = 4,
  parameter int DEPTH   = 4,
  parameter int DEPTH_W = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               entry_valid,
  input logic               entry_ack,
  input logic               ret,
  input logic [ID_W-1:0]    entry_id,
  input logic [ID_W-1:0]    active_id,
  input logic [DEPTH_W-1:0] depth,
  input logic [N_TOT-1:0]   pending,
  input rank_t              cand_rank,
  input rank_t              act_rank
);
  AST_OFFER_IS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    entry_valid |-> pending[entry_id]);  // R4
  AST_CLEAR_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_valid && entry_ack) |=> !pending[$past(entry_id)]);  // R2
  AST_STRICT_PREEMPT: assert property (@(posedge clk) disable iff (!rst_n)
    entry_valid |-> (cand_rank < act_rank));  // R6
  AST_SYS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_valid && (|pending[N_SYS-1:0])) |-> (int'(entry_id) < N_SYS));  // R8
  AST_PUSH_DEPTH: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_valid && entry_ack) |=> (depth == $past(depth) + 1'b1));  // R9
  AST_ACTIVE_ON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_valid && entry_ack) |=> (active_id == $past(entry_id)));  // R9
  AST_POP_DEPTH: assert property (@(posedge clk) disable iff (!rst_n)
    (ret && depth != '0) |=> (depth == $past(depth) - 1'b1));  // R10
  AST_RET_GATES_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    ret |-> !entry_valid);  // R10
  AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (depth == DEPTH_W'(DEPTH)) |-> !entry_valid);  // R11
endmodule

bind irq_prio_arbiter irq_arb_checker #(
  .N_TOT(N_TOT), .ID_W(ID_W), .DEPTH(DEPTH), .DEPTH_W(DEPTH_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .entry_valid(entry_valid_o),
  .entry_ack  (entry_ack_i),
  .ret        (ret_i),
  .entry_id   (entry_id_o),
  .active_id  (active_id_o),
  .depth      (depth_o),
  .pending    (pending_o),
  .cand_rank  (cand_rank),
  .act_rank   (act_rank)
);

// File: tb/irq_prio_arbiter_tb.sv
`timescale 1ns/1ps
module irq_prio_arbiter_tb_top;
  import irq_arb_pkg::*;
  localparam int NR = 8;
  localparam int DP = 4;
  localparam int NT = N_SYS + NR;
  localparam int IW = $clog2(NT);
  localparam int XW = $clog2(NR);
  localparam int DW = $clog2(DP + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NR-1:0]    req = '0;
  logic [N_SYS-1:0] sreq = '0;
  logic             prio_we = 1'b0;
  logic [XW-1:0]    prio_idx = '0;
  logic [PRIO_W-1:0] prio_wd = '0;
  logic             en_we = 1'b0;
  logic [NR-1:0]    en_wd = '1;
  logic             bp_we = 1'b0;
  logic [BP_W-1:0]  bp_wd = '0;
  logic             ack = 1'b1;
  logic             ret = 1'b0;
  logic             entry_valid, active_valid;
  logic [IW-1:0]    entry_id, active_id;
  logic [DW-1:0]    depth;
  logic [NT-1:0]    pending;

  always #2 clk = ~clk;

  irq_prio_arbiter #(.N_REQ(NR), .DEPTH(DP)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_i(req), .sys_req_i(sreq),
    .prio_we_i(prio_we), .prio_idx_i(prio_idx), .prio_wdata_i(prio_wd),
    .en_we_i(en_we), .en_wdata_i(en_wd), .bp_we_i(bp_we), .bp_wdata_i(bp_wd),
    .entry_ack_i(ack), .ret_i(ret),
    .entry_valid_o(entry_valid), .entry_id_o(entry_id),
    .active_valid_o(active_valid), .active_id_o(active_id),
    .depth_o(depth), .pending_o(pending)
  );

  int total = 0;
  int fails = 0;
  int cycles = 0;

  // Behavioural reference state
  logic [NT-1:0] m_pend = '0;
  int m_prio [NR];
  logic [NR-1:0] m_en = '1;
  int m_bp = 0;
  int m_act_rank = 31;
  int m_act_id = 0;
  int sv_rank [$];
  int sv_id [$];
  bit m_ev;
  int m_eid, m_erank;

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int level_of(int k);
    int sb, span;
    if (k < N_SYS) return k;
    sb   = (m_bp > PRIO_W) ? PRIO_W : m_bp;
    span = 2 ** sb;
    return N_SYS + m_prio[k-N_SYS] / span;
  endfunction

  function automatic int sub_lvl(int k);
    int sb;
    if (k < N_SYS) return 0;
    sb = (m_bp > PRIO_W) ? PRIO_W : m_bp;
    return m_prio[k-N_SYS] % (2 ** sb);
  endfunction

  task automatic model_eval();
    int br, bs;
    bit found;
    found = 0; br = 0; bs = 0; m_eid = 0;
    for (int k = 0; k < NT; k++) begin
      if (m_pend[k] && (k < N_SYS || m_en[k-N_SYS])) begin
        if (!found || level_of(k) < br ||
            (level_of(k) == br && sub_lvl(k) < bs)) begin
          found = 1; br = level_of(k); bs = sub_lvl(k); m_eid = k;
        end
      end
    end
    m_erank = br;
    m_ev = found && (br < m_act_rank) && (sv_rank.size() < DP) && !ret;
  endtask

  task automatic sample();
    @(negedge clk);
    #1;
    model_eval();
    chk("R4 entry_valid vs model", int'(entry_valid), int'(m_ev));
    if (m_ev) chk("R5 entry_id vs model", int'(entry_id), m_eid);
    chk("R2 pending vs model", int'(pending), int'(m_pend));
    chk("R9 depth vs model", int'(depth), sv_rank.size());
    chk("R9 active_valid vs model", int'(active_valid), int'(sv_rank.size() != 0));
    if (sv_rank.size() != 0) chk("R10 active_id vs model", int'(active_id), m_act_id);
  endtask

  task automatic advance();
    logic [NT-1:0] clr;
    @(posedge clk);
    clr = '0;
    if (m_ev && ack) clr[m_eid] = 1'b1;
    if (ret && sv_rank.size() > 0) begin
      m_act_rank = sv_rank.pop_back();
      m_act_id   = sv_id.pop_back();
    end else if (m_ev && ack) begin
      sv_rank.push_back(m_act_rank);
      sv_id.push_back(m_act_id);
      m_act_rank = m_erank;
      m_act_id   = m_eid;
    end
    m_pend = (m_pend | {req, sreq}) & ~clr;
    if (prio_we) m_prio[prio_idx] = int'(prio_wd);
    if (en_we)   m_en = en_wd;
    if (bp_we)   m_bp = int'(bp_wd);
    #1;
  endtask

  task automatic step(int n);
    for (int k = 0; k < n; k++) begin sample(); advance(); end
  endtask

  task automatic wr_prio(int i, int p);
    prio_we = 1'b1; prio_idx = XW'(i); prio_wd = PRIO_W'(p);
    step(1);
    prio_we = 1'b0;
  endtask

  task automatic wr_bp(int b);
    bp_we = 1'b1; bp_wd = BP_W'(b);
    step(1);
    bp_we = 1'b0;
  endtask

  task automatic do_ret(int n);
    ret = 1'b1;
    step(n);
    ret = 1'b0;
  endtask

  // Raise a configurable line for one cycle, then let it be taken
  task automatic pulse_req(int i);
    req[i] = 1'b1;
    step(1);
    req[i] = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == 20000) begin
      total++; fails++;
      $display("FAIL R1 watchdog expired: got %0d expected %0d", cycles, 0);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    int pv [NR] = '{8, 4, 4, 12, 6, 5, 7, 9};
    for (int k = 0; k < NR; k++) m_prio[k] = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    sample();
    chk("R1 reset entry_valid", int'(entry_valid), 0);
    chk("R1 reset depth", int'(depth), 0);
    chk("R1 reset pending", int'(pending), 0);
    chk("R1 reset active_valid", int'(active_valid), 0);
    advance();
    for (int k = 0; k < NR; k++) wr_prio(k, pv[k]);

    // R2 / R4: pending latency and idle entry
    ack = 1'b0;
    req[3] = 1'b1;
    sample();
    chk("R2 pending not yet set", int'(pending[6]), 0);
    advance();
    sample();
    chk("R2 pending set one edge later", int'(pending[6]), 1);
    chk("R4 idle offer id", int'(entry_id), 6);
    advance();
    req[3] = 1'b0; ack = 1'b1;
    step(1);
    sample();
    chk("R9 depth after entry", int'(depth), 1);
    chk("R9 active id after entry", int'(active_id), 6);
    chk("R2 pending cleared on accept", int'(pending[6]), 0);
    advance();

    // R5 / R6 / R10: equal priorities, strict preemption, return
    req[1] = 1'b1; req[2] = 1'b1;
    step(1);
    req = '0;
    sample();
    chk("R5 lowest index among equals", int'(entry_id), 4);
    advance();
    sample();
    chk("R6 equal group not offered", int'(entry_valid), 0);
    chk("R6 equal group stays pending", int'(pending[5]), 1);
    advance();
    ret = 1'b1;
    sample();
    chk("R10 no offer during return", int'(entry_valid), 0);
    advance();
    ret = 1'b0;
    sample();
    chk("R10 restored active id", int'(active_id), 6);
    chk("R10 re-evaluated offer", int'(entry_id), 5);
    advance();
    do_ret(2);

    // R7: binary point 2 -> groups of four levels
    wr_bp(2);
    pulse_req(4);
    step(1);
    pulse_req(5);
    sample();
    chk("R7 same group no preempt bp2", int'(entry_valid), 0);
    chk("R7 blocked request pending", int'(pending[8]), 1);
    advance();
    do_ret(1);
    sample();
    chk("R5 pending taken after return", int'(entry_id), 8);
    advance();
    do_ret(1);
    // R7: binary point 4 -> single group
    wr_bp(4);
    pulse_req(3);
    step(1);
    pulse_req(1);
    sample();
    chk("R7 no preemption with bp4", int'(entry_valid), 0);
    advance();
    do_ret(1);
    step(1);
    do_ret(1);
    wr_bp(0);

    // R3: enable mask keeps pending
    en_we = 1'b1; en_wd = 8'hFB;
    step(1);
    en_we = 1'b0;
    pulse_req(2);
    sample();
    chk("R3 masked line not offered", int'(entry_valid), 0);
    chk("R3 masked line stays pending", int'(pending[5]), 1);
    advance();
    step(1);
    en_we = 1'b1; en_wd = 8'hFF;
    step(1);
    en_we = 1'b0;
    sample();
    chk("R3 re-enabled line offered", int'(entry_id), 5);
    advance();
    do_ret(1);

    // R8 / R11: nest to full depth
    pulse_req(3); step(1);
    pulse_req(0); step(1);
    pulse_req(1); step(1);
    sreq[2] = 1'b1;
    step(1);
    sreq = '0;
    sample();
    chk("R8 system line preempts", int'(entry_id), 2);
    advance();
    sreq[0] = 1'b1;
    step(1);
    sreq = '0;
    sample();
    chk("R11 full stack blocks entry", int'(entry_valid), 0);
    chk("R11 depth at capacity", int'(depth), 4);
    chk("R11 blocked line pending", int'(pending[0]), 1);
    advance();
    do_ret(1);
    sample();
    chk("R8 system line after return", int'(entry_id), 0);
    advance();
    do_ret(4);
    sreq = 3'b110;
    step(1);
    sreq = '0;
    sample();
    chk("R8 lower system index wins", int'(entry_id), 1);
    advance();
    do_ret(1);
    step(1);
    do_ret(1);

    // R2: held level request re-pends after clear
    req[7] = 1'b1;
    step(2);
    sample();
    chk("R2 clear wins at accept", int'(pending[10]), 0);
    advance();
    sample();
    chk("R2 held level re-pends", int'(pending[10]), 1);
    advance();
    req[7] = 1'b0;
    do_ret(1);
    step(1);
    do_ret(1);
    step(3);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule